// File: doc/BRIEF.md
# Four-Phase Accumulator ALU Executor

This block is an 8-bit accumulator datapath that runs two instruction words: an add of the working register, a file register and the carry flag, and a bitwise AND of the working register with an 8-bit literal. Each instruction takes four clock cycles: a decode phase, an operand read phase, a process phase and a write-back phase. The block holds the working register (W), a five-bit status register, a bank select register and a banked byte memory. It forms a 12-bit effective address from the instruction's file field, its bank-mode bit and the bank select register.

The instruction word is presented on `instr_word` during the decode phase. A load port fills the memory and the bank select register before execution. A one-cycle read port lets the memory contents be observed. A mode input marks the extended-set condition. In that mode, a file operation in the access bank with a low address is flagged as unsupported and is not executed. Any encoding other than the two supported ones passes through four phases and changes nothing.

Top module: `quad_alu_exec`

## Requirements
- R1: After reset, W is 00h, every status bit is 0, the bank select register is 0, `phase_o` is 0 (decode) and `unsupported_o` is 0.
- R2: `phase_o` steps 0,1,2,3 and then returns to 0, one step per clock. `instr_word` is sampled at the clock edge that ends phase 0. W, status and memory change at the edge that ends phase 3.
- R3: Add-with-carry is encoded as bits[15:10]=001000, bit 9 = d, bit 8 = a, bits[7:0] = f. With d=0 the 8-bit value W + mem[ea] + C is written to W, and the file register is left unchanged.
- R4: With d=1 the add result is written to mem[ea], and W is left unchanged.
- R5: The add updates all five status bits: bit 0 C is the carry out of bit 7, bit 1 DC is the carry out of bit 3, bit 2 Z is set when the result is zero, bit 3 OV is set when both operands have the same sign and the result's sign differs, and bit 4 N is result bit 7.
- R6: AND-literal is encoded as bits[15:8]=0Bh with the literal in bits[7:0]. It writes W AND k to W, updates only N and Z, and keeps C, DC and OV.
- R7: With a=1 the effective address is {bank select, f}.
- R8: With a=0, f from 00h to 5Fh addresses bank 0 and f from 60h to FFh addresses bank 15 (address F00h+f).
- R9: When `ext_mode` is 1 at decode, a=0 and f ≤ 5Fh, an add sets `unsupported_o` from the process phase on and leaves W, status and memory unchanged. With f ≥ 60h it executes normally and clears `unsupported_o`.
- R10: Any other encoding changes no W, status or memory value and still takes exactly four phases.
- R11: `pre_we` writes `pre_data` to `pre_addr` at the clock edge. `bsr_load` loads `bsr_value`. `peek_data` shows mem[`peek_addr`] one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_word | input | 16 | Instruction, sampled at the end of phase 0 |
| ext_mode | input | 1 | Extended-set condition, sampled with the instruction |
| bsr_load | input | 1 | Load strobe for the bank select register |
| bsr_value | input | 4 | New bank select value |
| pre_we | input | 1 | Memory load write enable |
| pre_addr | input | 12 | Memory load address |
| pre_data | input | 8 | Memory load data |
| peek_addr | input | 12 | Observation read address |
| peek_data | output | 8 | Registered observation read data |
| w_reg_o | output | 8 | Working register |
| status_o | output | 5 | Status: bit4 N, bit3 OV, bit2 Z, bit1 DC, bit0 C |
| phase_o | output | 2 | Current phase, 0 = decode to 3 = write-back |
| unsupported_o | output | 1 | Last instruction hit the unsupported addressing case |

## Verification
An instruction is driven in the low half of a clock while `phase_o` is 0. Its W, status and memory results are due at the fourth rising edge after that, so the bench samples them at the falling edge that follows, when `phase_o` is back to 0. `unsupported_o` changes at the second edge and is read at the same point. Memory contents are read through the observation port, whose data is registered, so each address is held for one edge and the value is read at the next falling edge.

// File: rtl/quad_alu_pkg.sv
package quad_alu_pkg;
  localparam int INSTR_W = 16;
  localparam int ST_W    = 5;
  localparam int ST_C    = 0;
  localparam int ST_DC   = 1;
  localparam int ST_Z    = 2;
  localparam int ST_OV   = 3;
  localparam int ST_N    = 4;

  typedef enum logic [1:0] {
    PH_DECODE  = 2'd0,
    PH_READ    = 2'd1,
    PH_PROCESS = 2'd2,
    PH_WRITE   = 2'd3
  } phase_t;

  typedef enum logic [1:0] {
    OP_NOP  = 2'd0,
    OP_ADDC = 2'd1,
    OP_ANDL = 2'd2
  } op_t;

  function automatic op_t decode_op(logic [INSTR_W-1:0] iw);
    if (iw[15:10] == 6'b001000) return OP_ADDC;
    else if (iw[15:8] == 8'h0B) return OP_ANDL;
    else return OP_NOP;
  endfunction
endpackage

// File: rtl/qa_phase_seq.sv
module qa_phase_seq
  import quad_alu_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  output phase_t phase
);
  always_ff @(posedge clk) begin
    if (rst) phase <= PH_DECODE;
    else     phase <= phase_t'(phase + 2'd1);
  end

  assert_phase_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_WRITE) |=> (phase == PH_DECODE));
  assert_phase_step_R2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_READ) |=> (phase == PH_PROCESS));
endmodule

// File: rtl/qa_ea_gen.sv
module qa_ea_gen #(
  parameter int BANK_W = 4,
  parameter int FW     = 8,
  parameter logic [FW-1:0] SPLIT = 8'h60
) (
  input  logic              a_sel,
  input  logic [FW-1:0]     f,
  input  logic [BANK_W-1:0] bsr,
  output logic [BANK_W+FW-1:0] ea
);
  always_comb begin
    if (a_sel)          ea = {bsr, f};
    else if (f < SPLIT) ea = {{BANK_W{1'b0}}, f};
    else                ea = {{BANK_W{1'b1}}, f};
  end
endmodule

// File: rtl/qa_alu_core.sv
module qa_alu_core
  import quad_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  op_t             op,
  input  logic [DW-1:0]   w_in,
  input  logic [DW-1:0]   mem_in,
  input  logic [DW-1:0]   lit_in,
  input  logic            c_in,
  output logic [DW-1:0]   result,
  output logic [ST_W-1:0] flags,
  output logic [ST_W-1:0] flag_mask
);
  logic [DW:0] sum;
  logic [4:0]  low;

  always_comb begin
    sum       = {1'b0, w_in} + {1'b0, mem_in} + {{DW{1'b0}}, c_in};
    low       = {1'b0, w_in[3:0]} + {1'b0, mem_in[3:0]} + {4'b0, c_in};
    flags     = '0;
    flag_mask = '0;
    result    = '0;
    case (op)
      OP_ADDC: begin
        result       = sum[DW-1:0];
        flags[ST_C]  = sum[DW];
        flags[ST_DC] = low[4];
        flags[ST_OV] = (w_in[DW-1] == mem_in[DW-1]) && (sum[DW-1] != w_in[DW-1]);
        flag_mask    = '1;
      end
      OP_ANDL: begin
        result          = w_in & lit_in;
        flag_mask[ST_N] = 1'b1;
        flag_mask[ST_Z] = 1'b1;
      end
      default: ;
    endcase
    flags[ST_N] = result[DW-1];
    flags[ST_Z] = (result == '0);
  end
endmodule

// File: rtl/qa_bank_ram.sv
module qa_bank_ram #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  input  logic [AW-1:0] paddr,
  output logic [DW-1:0] pdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
    pdata <= mem[paddr];
  end
endmodule

// File: rtl/quad_alu_exec.sv
module quad_alu_exec
  import quad_alu_pkg::*;
#(
  parameter int DW     = 8,
  parameter int BANK_W = 4,
  parameter logic [7:0] SPLIT = 8'h60
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [15:0]          instr_word,
  input  logic                 ext_mode,
  input  logic                 bsr_load,
  input  logic [BANK_W-1:0]    bsr_value,
  input  logic                 pre_we,
  input  logic [BANK_W+7:0]    pre_addr,
  input  logic [DW-1:0]        pre_data,
  input  logic [BANK_W+7:0]    peek_addr,
  output logic [DW-1:0]        peek_data,
  output logic [DW-1:0]        w_reg_o,
  output logic [ST_W-1:0]      status_o,
  output logic [1:0]           phase_o,
  output logic                 unsupported_o
);
  localparam int FW = 8;
  localparam int AW = BANK_W + FW;

  phase_t            phase;
  logic [15:0]       ir_q;
  logic              ext_q;
  logic              exec_q;
  logic              unsup_q;
  logic [DW-1:0]     w_q;
  logic [ST_W-1:0]   status_q;
  logic [BANK_W-1:0] bsr_q;
  logic [DW-1:0]     res_q;
  logic [ST_W-1:0]   flag_q, mask_q;

  op_t             op;
  logic            d_bit, a_bit, lit_offset, file_wr;
  logic [FW-1:0]   f_fld;
  logic [AW-1:0]   ea, ram_waddr;
  logic [DW-1:0]   ram_rdata, alu_res, ram_wdata;
  logic [ST_W-1:0] alu_flags, alu_mask;
  logic            ram_we;

  assign op    = decode_op(ir_q);
  assign d_bit = ir_q[9];
  assign a_bit = ir_q[8];
  assign f_fld = ir_q[7:0];
  assign lit_offset = ext_q && (op == OP_ADDC) && !a_bit && (f_fld <= 8'h5F);

  qa_phase_seq u_seq (.clk(clk), .rst(rst), .phase(phase));

  qa_ea_gen #(.BANK_W(BANK_W), .FW(FW), .SPLIT(SPLIT)) u_ea (
    .a_sel(a_bit), .f(f_fld), .bsr(bsr_q), .ea(ea));

  qa_alu_core #(.DW(DW)) u_alu (
    .op(op), .w_in(w_q), .mem_in(ram_rdata), .lit_in(DW'(f_fld)),
    .c_in(status_q[ST_C]), .result(alu_res), .flags(alu_flags), .flag_mask(alu_mask));

  assign file_wr   = (phase == PH_WRITE) && exec_q && (op == OP_ADDC) && d_bit;
  assign ram_we    = file_wr || pre_we;
  assign ram_waddr = file_wr ? ea : pre_addr;
  assign ram_wdata = file_wr ? res_q : pre_data;

  qa_bank_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ea), .rdata(ram_rdata), .paddr(peek_addr), .pdata(peek_data));

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_q     <= '0;
      ext_q    <= 1'b0;
      exec_q   <= 1'b0;
      unsup_q  <= 1'b0;
      w_q      <= '0;
      status_q <= '0;
      bsr_q    <= '0;
      res_q    <= '0;
      flag_q   <= '0;
      mask_q   <= '0;
    end else begin
      if (bsr_load) bsr_q <= bsr_value;
      case (phase)
        PH_DECODE: begin
          ir_q  <= instr_word;
          ext_q <= ext_mode;
        end
        PH_READ: begin
          unsup_q <= lit_offset;
          exec_q  <= (op != OP_NOP) && !lit_offset;
        end
        PH_PROCESS: begin
          res_q  <= alu_res;
          flag_q <= alu_flags;
          mask_q <= alu_mask;
        end
        PH_WRITE: begin
          if (exec_q) begin
            if (!(op == OP_ADDC && d_bit)) w_q <= res_q;
            status_q <= (status_q & ~mask_q) | (flag_q & mask_q);
          end
        end
        default: ;
      endcase
    end
  end

  assign w_reg_o       = w_q;
  assign status_o      = status_q;
  assign phase_o       = phase;
  assign unsupported_o = unsup_q;

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (phase == PH_DECODE && w_q == '0 && status_q == '0 && !unsup_q));
  assert_dest_file_keeps_w_R4: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_WRITE && op == OP_ADDC && d_bit) |=> $stable(w_q));
  assert_and_keeps_flags_R6: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_WRITE && op == OP_ANDL) |=>
      ($stable(status_q[ST_C]) && $stable(status_q[ST_DC]) && $stable(status_q[ST_OV])));
  assert_unsup_no_exec_R9: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_WRITE && unsup_q) |=> ($stable(w_q) && $stable(status_q)));
  assert_nop_no_change_R10: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_WRITE && op == OP_NOP) |=> ($stable(w_q) && $stable(status_q)));
  assert_bsr_load_R11: assert property (@(posedge clk) disable iff (rst)
    bsr_load |=> (bsr_q == $past(bsr_value)));
endmodule

// File: tb/quad_alu_exec_bench.sv
module quad_alu_exec_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] instr_word = '0;
  logic        ext_mode = 1'b0;
  logic        bsr_load = 1'b0;
  logic [3:0]  bsr_value = '0;
  logic        pre_we = 1'b0;
  logic [11:0] pre_addr = '0;
  logic [7:0]  pre_data = '0;
  logic [11:0] peek_addr = '0;
  logic [7:0]  peek_data, w_reg_o;
  logic [4:0]  status_o;
  logic [1:0]  phase_o;
  logic        unsupported_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  quad_alu_exec u_quad_alu_exec (
    .clk(clk), .rst(rst), .instr_word(instr_word), .ext_mode(ext_mode),
    .bsr_load(bsr_load), .bsr_value(bsr_value), .pre_we(pre_we),
    .pre_addr(pre_addr), .pre_data(pre_data), .peek_addr(peek_addr),
    .peek_data(peek_data), .w_reg_o(w_reg_o), .status_o(status_o),
    .phase_o(phase_o), .unsupported_o(unsupported_o));

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic preload(logic [11:0] a, logic [7:0] d);
    pre_we = 1'b1; pre_addr = a; pre_data = d;
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  task automatic peek_check(string tag, logic [11:0] a, logic [7:0] exp);
    peek_addr = a;
    @(negedge clk);
    check(tag, {8'h0, peek_data}, {8'h0, exp});
  endtask

  task automatic exec(logic [15:0] iw);
    while (phase_o != 2'd0) @(negedge clk);
    instr_word = iw;
    repeat (4) @(negedge clk);
    instr_word = 16'h0000;
  endtask

  task automatic expect_state(string tag, logic [7:0] w, logic [4:0] st);
    check({tag, " W"}, {8'h0, w_reg_o}, {8'h0, w});
    check({tag, " status"}, {11'h0, status_o}, {11'h0, st});
  endtask

  task automatic t_reset;
    check("R1 W", {8'h0, w_reg_o}, 16'h0);
    check("R1 status", {11'h0, status_o}, 16'h0);
    check("R1 phase", {14'h0, phase_o}, 16'h0);
    check("R1 unsupported", {15'h0, unsupported_o}, 16'h0);
  endtask

  task automatic t_phase;
    while (phase_o != 2'd0) @(negedge clk);
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      check("R2 phase step", {14'h0, phase_o}, 16'(i % 4));
    end
  endtask

  task automatic t_add;
    preload(12'h010, 8'hFF);
    preload(12'h011, 8'h4E);
    preload(12'h012, 8'h02);
    exec(16'h2010); expect_state("R3 R5 add FF", 8'hFF, 5'h10);
    exec(16'h2011); expect_state("R3 R5 add carry", 8'h4D, 5'h03);
    exec(16'h2012); expect_state("R3 R5 add 4D+02+C", 8'h50, 5'h02);
    peek_check("R3 file unchanged", 12'h012, 8'h02);
  endtask

  task automatic t_and;
    preload(12'h013, 8'h53);
    exec(16'h2013); expect_state("R5 overflow", 8'hA3, 5'h18);
    exec(16'h0B5F); expect_state("R6 and 5F", 8'h03, 5'h08);
    exec(16'h0B00); expect_state("R6 and zero", 8'h00, 5'h0C);
  endtask

  task automatic t_zero_carry;
    preload(12'h014, 8'hFF);
    preload(12'h015, 8'h01);
    preload(12'h016, 8'h7E);
    exec(16'h2014); expect_state("R5 add clears OV", 8'hFF, 5'h10);
    exec(16'h2015); expect_state("R5 zero carry", 8'h00, 5'h07);
    exec(16'h2016); expect_state("R5 carry in", 8'h7F, 5'h00);
  endtask

  task automatic t_bank;
    bsr_load = 1'b1; bsr_value = 4'h3;
    @(negedge clk);
    bsr_load = 1'b0;
    preload(12'h320, 8'h01);
    preload(12'h020, 8'h55);
    exec(16'h2320); expect_state("R4 R7 to file", 8'h7F, 5'h1A);
    peek_check("R4 R7 file written", 12'h320, 8'h80);
    peek_check("R7 bank0 untouched", 12'h020, 8'h55);
  endtask

  task automatic t_access;
    preload(12'hFA0, 8'h01);
    preload(12'h0A0, 8'h77);
    preload(12'h3A0, 8'h66);
    exec(16'h22A0); expect_state("R8 upper access", 8'h7F, 5'h1A);
    peek_check("R8 bank15 written", 12'hFA0, 8'h80);
    peek_check("R8 bank0 kept", 12'h0A0, 8'h77);
    peek_check("R8 bsr bank kept", 12'h3A0, 8'h66);
    preload(12'h05F, 8'h01);
    preload(12'hF5F, 8'h02);
    exec(16'h205F); expect_state("R8 f=5F bank0", 8'h80, 5'h1A);
    preload(12'hF60, 8'h00);
    preload(12'h060, 8'h05);
    exec(16'h2060); expect_state("R8 f=60 bank15", 8'h80, 5'h10);
  endtask

  task automatic t_unsup;
    ext_mode = 1'b1;
    exec(16'h2012); expect_state("R9 no exec", 8'h80, 5'h10);
    check("R9 flag", {15'h0, unsupported_o}, 16'h1);
    exec(16'h2212);
    peek_check("R9 file kept", 12'h012, 8'h02);
    check("R9 flag d1", {15'h0, unsupported_o}, 16'h1);
    exec(16'h205F); expect_state("R9 f=5F", 8'h80, 5'h10);
    exec(16'h20A0); expect_state("R9 f=A0 runs", 8'h00, 5'h0D);
    check("R9 flag cleared", {15'h0, unsupported_o}, 16'h0);
    ext_mode = 1'b0;
  endtask

  task automatic t_nop;
    exec(16'hFFFF); expect_state("R10 FFFF", 8'h00, 5'h0D);
    check("R10 four phases", {14'h0, phase_o}, 16'h0);
    exec(16'h2400); expect_state("R10 2400", 8'h00, 5'h0D);
    peek_check("R10 mem kept", 12'h000 + 12'h016, 8'h7E);
    exec(16'h0000); expect_state("R10 0000", 8'h00, 5'h0D);
  endtask

  task automatic t_peek_latency;
    preload(12'h700, 8'hC3);
    peek_addr = 12'h700;
    @(negedge clk);
    check("R11 peek one cycle", {8'h0, peek_data}, 16'h00C3);
  endtask

  task automatic t_mid_reset;
    rst = 1'b1;
    @(negedge clk);
    t_reset();
    rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_phase();
    t_add();
    t_and();
    t_zero_carry();
    t_bank();
    t_access();
    t_unsup();
    t_nop();
    t_peek_latency();
    t_mid_reset();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule